// File: doc/BRIEF.md
# Ramp Test Pattern Source

This block produces a synthetic 12-bit ramp that stands in for sensor video on a pixel stream. It follows the stream's line-valid and frame-valid strobes and its per-pixel enable. Within a line it turns the position of each enabled pixel into a ramp code. Across frames it keeps a start offset that stays at zero in fixed mode and creeps upward in sliding mode. A registered select output tells the downstream video multiplexer to take the ramp in place of sensor data.

A 2-bit selector picks the behaviour. When the pattern is chosen, the stage that formats output bit depth is the only one still acting on the pixels. Gain and offset, the lookup table and column correction are all bypassed by the external multiplexer under control of `pat_active`. The sliding offset is there so that a receiver can see the picture move and confirm, frame by frame, that the link is alive.

Top module: `tpg_top`

## Requirements
- R1: While `rst_n` is low, `pat_px` is 0 and `pat_active` is 0.
- R2: One clock after `sel` is sampled, `pat_active` is 1 for sel=2'b01 (fixed) or sel=2'b10 (sliding), and 0 for sel=2'b00 (sensor video) or the unused value 2'b11.
- R3: The pixel index restarts at 0 whenever `lval` is low. The first enabled pixel of each line gives code (960 + offset) mod 4096.
- R4: The k-th enabled pixel of a line (k from 0) gives code (960 + offset + floor((k+1)/2)) mod 4096. `pat_px` shows it one clock after the edge that samples `pix_en` and `lval` both high.
- R5: With offset 0, pixel k=2095 of a line gives code 2008. Pixels past index 2095 in the same line repeat the code of index 2095.
- R6: In fixed mode the offset is 0 on every line of every frame.
- R7: In sliding mode the offset is 0 for the first frame that starts after sliding is selected. Each later rising edge of `fval` that is sampled in sliding mode adds 2 to it.
- R8: The offset and the sum that forms the pixel code both wrap modulo 4096.
- R9: Any clock on which `sel` is not 2'b10 clears the offset, so the next line in any mode starts from the offset-0 code.
- R10: `pat_px` holds its value on any clock where `pix_en` or `lval` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Pattern selector: 00 video, 01 fixed ramp, 10 sliding ramp, 11 unused (video) |
| fval | input | 1 | Frame-valid strobe of the stream |
| lval | input | 1 | Line-valid strobe of the stream |
| pix_en | input | 1 | Active pixel enable within a line |
| pat_px | output | 12 | Ramp code for the last enabled pixel |
| pat_active | output | 1 | Multiplexer select: 1 takes the ramp instead of sensor video |

## Verification
The ramp is driven with one full-width line that runs three pixels past the nominal width. This separates the half-rate slope, the 2008 end code and index saturation from an index that wraps. Short lines with random lengths and random gaps in `pix_en` test holding against advancing and the index restart on `lval`. A long run of sliding frames carries the offset past 4096 and shows modular wrap against saturation. Random switches between all four selector values test the first-frame-at-zero rule and offset clearing against an offset that carries over.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    PM_VIDEO = 2'b00,
    PM_FIXED = 2'b01,
    PM_SLIDE = 2'b10,
    PM_SPARE = 2'b11
  } pat_mode_e;
endpackage

// File: rtl/tpg_mode_dec.sv
module tpg_mode_dec
  import tpg_pkg::*;
(
  input  logic [1:0] sel,
  output logic       use_pat,
  output logic       use_slide
);
  pat_mode_e mode;

  always_comb begin
    mode      = pat_mode_e'(sel);
    use_pat   = (mode == PM_FIXED) || (mode == PM_SLIDE);
    use_slide = (mode == PM_SLIDE);
  end
endmodule

// File: rtl/tpg_slide_ofs.sv
module tpg_slide_ofs #(
  parameter int PIX_W      = 12,
  parameter int SLIDE_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_slide,
  input  logic             fval,
  output logic [PIX_W-1:0] ofs
);
  logic             fval_q;
  logic             armed_q, armed_nxt;
  logic [PIX_W-1:0] ofs_q, ofs_nxt;
  logic             frame_rise;

  always_comb begin
    frame_rise = fval && !fval_q;
    armed_nxt  = armed_q;
    ofs_nxt    = ofs_q;
    if (!use_slide) begin
      armed_nxt = 1'b0;
      ofs_nxt   = '0;
    end else if (frame_rise) begin
      armed_nxt = 1'b1;
      if (armed_q) ofs_nxt = ofs_q + PIX_W'(SLIDE_STEP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fval_q  <= 1'b0;
      armed_q <= 1'b0;
      ofs_q   <= '0;
    end else begin
      fval_q  <= fval;
      armed_q <= armed_nxt;
      ofs_q   <= ofs_nxt;
    end
  end

  assign ofs = ofs_q;
endmodule

// File: rtl/tpg_ramp.sv
module tpg_ramp #(
  parameter int PIX_W      = 12,
  parameter int LINE_PIX   = 2096,
  parameter int RAMP_START = 960,
  parameter int RAMP_SHIFT = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lval,
  input  logic                        pix_en,
  input  logic [PIX_W-1:0]            ofs,
  output logic [PIX_W-1:0]            px,
  output logic [$clog2(LINE_PIX)-1:0] idx
);
  localparam int IDX_W = $clog2(LINE_PIX);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LINE_PIX - 1);

  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic [PIX_W-1:0] px_q, px_nxt;
  logic [IDX_W:0]   half;
  logic             px_ce;

  always_comb begin
    px_ce   = lval && pix_en;
    half    = ({1'b0, idx_q} + 1'b1) >> RAMP_SHIFT;
    idx_nxt = idx_q;
    px_nxt  = px_q;
    if (!lval) begin
      idx_nxt = '0;
    end else if (px_ce) begin
      px_nxt = PIX_W'(RAMP_START) + ofs + PIX_W'(half);
      if (idx_q != IDX_LAST) idx_nxt = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      px_q  <= '0;
    end else begin
      idx_q <= idx_nxt;
      px_q  <= px_nxt;
    end
  end

  assign px  = px_q;
  assign idx = idx_q;
endmodule

// File: rtl/tpg_top.sv
module tpg_top #(
  parameter int PIX_W      = 12,
  parameter int LINE_PIX   = 2096,
  parameter int RAMP_START = 960,
  parameter int RAMP_SHIFT = 1,
  parameter int SLIDE_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic             fval,
  input  logic             lval,
  input  logic             pix_en,
  output logic [PIX_W-1:0] pat_px,
  output logic             pat_active
);
  localparam int IDX_W = $clog2(LINE_PIX);

  logic             use_pat, use_slide;
  logic [PIX_W-1:0] slide_ofs;
  logic [IDX_W-1:0] pix_idx;
  logic             act_q, act_nxt;

  tpg_mode_dec u_dec (
    .sel       (sel),
    .use_pat   (use_pat),
    .use_slide (use_slide)
  );

  tpg_slide_ofs #(.PIX_W(PIX_W), .SLIDE_STEP(SLIDE_STEP)) u_slide (
    .clk       (clk),
    .rst_n     (rst_n),
    .use_slide (use_slide),
    .fval      (fval),
    .ofs       (slide_ofs)
  );

  tpg_ramp #(
    .PIX_W(PIX_W), .LINE_PIX(LINE_PIX),
    .RAMP_START(RAMP_START), .RAMP_SHIFT(RAMP_SHIFT)
  ) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .lval   (lval),
    .pix_en (pix_en),
    .ofs    (slide_ofs),
    .px     (pat_px),
    .idx    (pix_idx)
  );

  always_comb act_nxt = use_pat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_nxt;
  end

  assign pat_active = act_q;
endmodule

// File: rtl/tpg_chk.sv
module tpg_chk #(
  parameter int PIX_W      = 12,
  parameter int LINE_PIX   = 2096,
  parameter int SLIDE_STEP = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [1:0]                  sel,
  input logic                        lval,
  input logic                        pix_en,
  input logic [PIX_W-1:0]            pat_px,
  input logic                        pat_active,
  input logic [PIX_W-1:0]            slide_ofs,
  input logic [$clog2(LINE_PIX)-1:0] pix_idx
);
  a_r2_mux_select: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pat_active == ($past(sel) == 2'b01 || $past(sel) == 2'b10)));

  a_r5_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pix_idx <= ($clog2(LINE_PIX))'(LINE_PIX - 1));

  a_r7_slide_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b10) |=> (slide_ofs == $past(slide_ofs) ||
                        slide_ofs == $past(slide_ofs) + PIX_W'(SLIDE_STEP)));

  a_r9_offset_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != 2'b10) |=> (slide_ofs == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_en && lval) |=> $stable(pat_px));
endmodule

bind tpg_top tpg_chk #(.PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .SLIDE_STEP(SLIDE_STEP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel),
  .lval       (lval),
  .pix_en     (pix_en),
  .pat_px     (pat_px),
  .pat_active (pat_active),
  .slide_ofs  (slide_ofs),
  .pix_idx    (pix_idx)
);

// File: tb/test_tpg_top.sv
module test_tpg_top;
  logic        clk;
  logic        rst_n;
  logic [1:0]  sel;
  logic        fval, lval, pix_en;
  logic [11:0] pat_px;
  logic        pat_active;

  int checks = 0;
  int errors = 0;
  logic [11:0] m_ofs;
  bit          m_armed;
  logic [1:0]  m_sel;
  int unsigned seed_sink;

  tpg_top i_tpg_top (
    .clk(clk), .rst_n(rst_n), .sel(sel), .fval(fval), .lval(lval),
    .pix_en(pix_en), .pat_px(pat_px), .pat_active(pat_active)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [11:0] exp_px(logic [11:0] ofs, int k);
    int kk;
    kk = (k > 2095) ? 2095 : k;
    return 12'(960 + int'(ofs) + ((kk + 1) >> 1));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_sel(logic [1:0] v);
    @(negedge clk);
    sel   = v;
    m_sel = v;
    if (v != 2'b10) begin m_ofs = '0; m_armed = 1'b0; end
    @(negedge clk);
    check("R2 mux select", int'(pat_active), int'(v == 2'b01 || v == 2'b10));
  endtask

  task automatic frame_start();
    @(negedge clk);
    fval = 1'b1;
    if (m_sel == 2'b10) begin
      if (m_armed) m_ofs = m_ofs + 12'd2;
      m_armed = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic frame_end();
    @(negedge clk);
    fval = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_line(int npix, int gap_pct, string req);
    logic [11:0] held;
    @(negedge clk);
    lval = 1'b1;
    for (int k = 0; k < npix; k++) begin
      if (($urandom % 100) < gap_pct) begin
        held   = pat_px;
        pix_en = 1'b0;
        @(negedge clk);
        check("R10 hold on gap", int'(pat_px), int'(held));
      end
      pix_en = 1'b1;
      @(negedge clk);
      check(req, int'(pat_px), int'(exp_px(m_ofs, k)));
      if (k == 0) check("R3 line start", int'(pat_px), int'(12'(960 + int'(m_ofs))));
    end
    pix_en = 1'b0;
    lval   = 1'b0;
    held   = pat_px;
    @(negedge clk);
    pix_en = 1'b1;
    @(negedge clk);
    check("R10 hold lval low", int'(pat_px), int'(held));
    pix_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seed_sink = $urandom(32'h5a17);
    rst_n = 1'b0; sel = 2'b00; fval = 0; lval = 0; pix_en = 0;
    m_ofs = '0; m_armed = 0; m_sel = 2'b00;
    repeat (3) @(negedge clk);
    check("R1 reset px", int'(pat_px), 0);
    check("R1 reset sel", int'(pat_active), 0);
    rst_n = 1'b1;

    // Fixed mode: full line beyond nominal width
    set_sel(2'b01);
    frame_start();
    run_line(2099, 0, "R4 ramp slope");
    frame_end();
    // explicit end code: index 2095 gives 2008, saturation beyond
    check("R5 end code", int'(exp_px(12'd0, 2095)), 2008);
    check("R5 saturated px", int'(pat_px), 2008);
    for (int f = 0; f < 3; f++) begin
      frame_start();
      run_line(5 + f, 30, "R6 fixed frame");
      frame_end();
    end

    set_sel(2'b11);
    set_sel(2'b00);

    // Sliding mode
    set_sel(2'b10);
    for (int f = 0; f < 6; f++) begin
      frame_start();
      run_line(1 + ($urandom % 8), 25, "R7 sliding step");
      run_line(3, 0, "R7 sliding second line");
      frame_end();
    end

    // Long sliding run to cross modular wrap
    for (int f = 0; f < 1600; f++) begin
      frame_start();
      frame_end();
    end
    frame_start();
    run_line(6, 0, "R8 wrap");
    frame_end();
    for (int f = 0; f < 500; f++) begin
      frame_start();
      frame_end();
    end
    frame_start();
    run_line(4, 0, "R8 offset wrap");
    frame_end();

    // Leaving sliding clears the offset
    set_sel(2'b01);
    frame_start();
    run_line(3, 0, "R9 cleared offset");
    frame_end();
    check("R9 model offset zero", int'(m_ofs), 0);

    // Random mix
    for (int it = 0; it < 300; it++) begin
      if (($urandom % 5) == 0) set_sel(2'($urandom % 4));
      frame_start();
      for (int l = 0; l < 1 + int'($urandom % 3); l++)
        run_line(1 + ($urandom % 10), 20, "R4 random line");
      frame_end();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule